// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block freezes a copy of the running calendar time whenever a tamper channel reports an event. It serves up to four channels. For each channel it keeps a control byte and a six-field BCD record: seconds, minutes, hours, day of month, month and year. A calendar counter outside the block supplies the current time. A pin-level resolver, also outside the block, turns each tamper pin into two single-cycle pulses. One pulse means the pin was pulled to ground. The other means the pin sat at an intermediate level. Both kinds of event feed the same record, but each sets its own sticky flag.

Software uses a plain register port. A write is taken on the clock edge where `wr_en` is high, and a read is a combinational decode of `addr`. The port has no back-pressure: every access completes in the cycle it is presented, so the port carries no ready signal. The interrupt output `irq_n` is active low. It is a level that stays low while any channel with its interrupt enabled holds a flag.

Each channel has two modes, chosen by a control bit. In hold mode the channel keeps the first event until software clears that channel's flags. In overwrite mode every accepted event replaces the record.

Top module: `tamper_stamp`

## Requirements
- R1: After reset, every flag and interrupt enable is 0, `irq_n` is 1, every control byte reads 0x40 (capture off) and every record byte reads 0x00.
- R2: Channel n (0-based) occupies addresses 8n to 8n+6. The control byte is at offset 0. Offsets 1 to 6 hold seconds, minutes, hours, day, month and year. Each stored field is masked: seconds and minutes with 0x7F, hours and day with 0x3F, month with 0x1F, year with 0xFF.
- R3: While control bit 6 of a channel is 1, its events set no flag and leave the record unchanged.
- R4: A ground event on an enabled channel sets its ground flag in the status register at address 0x20. Channel n uses bit 7-n. The flag reads as set one cycle later. On the same edge, all six time fields are stored from the values present at that edge.
- R5: An intermediate-level event on an enabled channel sets its intermediate flag in the register at address 0x22 (bit 7-n) and captures time into the same record. The ground flag is not changed.
- R6: With control bit 7 = 1 (hold mode), a new event does not change the record while either flag of that channel is set.
- R7: With control bit 7 = 0 (overwrite mode), each accepted event replaces the record.
- R8: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit has no effect. If an event arrives in the same cycle as a clear, the flag ends up set.
- R9: `irq_n` is 0 exactly when some channel n has a flag (ground or intermediate) set and bit 7-n of the enable register at 0x21 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| evt_low | input | NCH | Per-channel ground event pulse |
| evt_mid | input | NCH | Per-channel intermediate-level event pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational |
| flag_low | output | NCH | Ground flags |
| flag_mid | output | NCH | Intermediate flags |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The assertions assume that each event input is a clean, synchronous pulse. They also assume that the time inputs are stable around the capturing edge. Under those assumptions, a flag set one cycle after an event depends only on that channel's control byte. The stimulus drives the events and the time bus together on the falling edge, and moves the time to unrelated values on the next falling edge. A captured record therefore shows which edge it was taken on. Register writes and events are also applied on falling edges, and the stimulus places a flag clear and an event in the same cycle on purpose to exercise the set-wins rule.

// File: rtl/tts_pkg.sv
`timescale 1ns/1ps
package tts_pkg;
  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } stamp_t;

  localparam int        OFF_BIT    = 6;
  localparam int        HOLD_BIT   = 7;
  localparam logic [7:0] CTRL_INIT = 8'h40;
  localparam int        SLOT_BYTES = 8;

  function automatic stamp_t mask_stamp(input stamp_t s);
    stamp_t m;
    m.sec  = s.sec  & 8'h7F;
    m.min  = s.min  & 8'h7F;
    m.hour = s.hour & 8'h3F;
    m.day  = s.day  & 8'h3F;
    m.mon  = s.mon  & 8'h1F;
    m.year = s.year;
    return m;
  endfunction
endpackage

// File: rtl/tts_channel.sv
`timescale 1ns/1ps
module tts_channel
  import tts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  stamp_t     now,
  input  logic       evt_low,
  input  logic       evt_mid,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       clr_low,
  input  logic       clr_mid,
  output logic [7:0] ctrl,
  output stamp_t     rec,
  output logic       flag_low,
  output logic       flag_mid
);
  logic armed, holding, take;

  assign armed   = !ctrl[OFF_BIT];
  assign holding = ctrl[HOLD_BIT] && (flag_low || flag_mid);
  assign take    = armed && (evt_low || evt_mid) && !holding;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= CTRL_INIT;
      rec      <= '0;
      flag_low <= 1'b0;
      flag_mid <= 1'b0;
    end else begin
      if (ctrl_we) ctrl <= ctrl_wdata;
      if (take) rec <= mask_stamp(now);
      flag_low <= (flag_low && !clr_low) || (armed && evt_low);
      flag_mid <= (flag_mid && !clr_mid) || (armed && evt_mid);
    end
  end

  assert_off_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[OFF_BIT] && !flag_low && !flag_mid) |=> (!flag_low && !flag_mid));

  assert_low_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_low && armed) |=> flag_low);

  assert_mid_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mid && armed) |=> flag_mid);

  assert_hold_keeps_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
    holding |=> $stable(rec));

  assert_clear_without_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_low && !evt_low) |=> !flag_low);
endmodule

// File: rtl/tts_irq.sv
`timescale 1ns/1ps
module tts_irq #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] flag_low,
  input  logic [NCH-1:0] flag_mid,
  input  logic [NCH-1:0] ie,
  output logic           irq_n
);
  logic [NCH-1:0] pending;

  always_comb begin
    for (int i = 0; i < NCH; i++) pending[i] = (flag_low[i] | flag_mid[i]) & ie[i];
  end

  assign irq_n = !(|pending);
endmodule

// File: rtl/tamper_stamp.sv
`timescale 1ns/1ps
module tamper_stamp
  import tts_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] IE_ADDR   = 'h21,
  parameter logic [ADDR_W-1:0] MID_ADDR  = 'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [7:0]        now_day,
  input  logic [7:0]        now_mon,
  input  logic [7:0]        now_year,
  input  logic [NCH-1:0]    evt_low,
  input  logic [NCH-1:0]    evt_mid,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NCH-1:0]    flag_low,
  output logic [NCH-1:0]    flag_mid,
  output logic              irq_n
);
  localparam int SLOT_W = $clog2(SLOT_BYTES);
  localparam int CH_W   = ADDR_W - SLOT_W;
  localparam int RECORD_END = NCH * SLOT_BYTES;

  stamp_t         now;
  logic [7:0]     ctrl_q [NCH];
  stamp_t         rec_q  [NCH];
  logic [NCH-1:0] ie_q;
  logic [CH_W-1:0]   sel_ch;
  logic [SLOT_W-1:0] sel_off;

  assign now     = '{sec: now_sec, min: now_min, hour: now_hour,
                     day: now_day, mon: now_mon, year: now_year};
  assign sel_ch  = addr[ADDR_W-1:SLOT_W];
  assign sel_off = addr[SLOT_W-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ctrl_hit, clr_l, clr_m;
    assign ctrl_hit = wr_en && (addr == ADDR_W'(i * SLOT_BYTES));
    assign clr_l    = wr_en && (addr == STAT_ADDR) && !wdata[7-i];
    assign clr_m    = wr_en && (addr == MID_ADDR)  && !wdata[7-i];

    tts_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .now        (now),
      .evt_low    (evt_low[i]),
      .evt_mid    (evt_mid[i]),
      .ctrl_we    (ctrl_hit),
      .ctrl_wdata (wdata),
      .clr_low    (clr_l),
      .clr_mid    (clr_m),
      .ctrl       (ctrl_q[i]),
      .rec        (rec_q[i]),
      .flag_low   (flag_low[i]),
      .flag_mid   (flag_mid[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) ie_q[i] <= 1'b0;
      else if (wr_en && addr == IE_ADDR) ie_q[i] <= wdata[7-i];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == STAT_ADDR) begin
      for (int i = 0; i < NCH; i++) rdata[7-i] = flag_low[i];
    end else if (addr == MID_ADDR) begin
      for (int i = 0; i < NCH; i++) rdata[7-i] = flag_mid[i];
    end else if (addr == IE_ADDR) begin
      for (int i = 0; i < NCH; i++) rdata[7-i] = ie_q[i];
    end else if (int'(addr) < RECORD_END) begin
      for (int i = 0; i < NCH; i++) begin
        if (sel_ch == CH_W'(i)) begin
          case (sel_off)
            SLOT_W'(0): rdata = ctrl_q[i];
            SLOT_W'(1): rdata = rec_q[i].sec;
            SLOT_W'(2): rdata = rec_q[i].min;
            SLOT_W'(3): rdata = rec_q[i].hour;
            SLOT_W'(4): rdata = rec_q[i].day;
            SLOT_W'(5): rdata = rec_q[i].mon;
            SLOT_W'(6): rdata = rec_q[i].year;
            default:    rdata = 8'h00;
          endcase
        end
      end
    end
  end

  tts_irq #(.NCH(NCH)) u_irq (
    .flag_low (flag_low),
    .flag_mid (flag_mid),
    .ie       (ie_q),
    .irq_n    (irq_n)
  );

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|(flag_low | flag_mid)));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> irq_n);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (flag_low == '0 && flag_mid == '0 && irq_n));
endmodule

// File: tb/tamper_stamp_bench.sv
`timescale 1ns/1ps
module tamper_stamp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0, now_mon = '0, now_year = '0;
  logic [3:0] evt_low = '0, evt_mid = '0;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] flag_low, flag_mid;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tamper_stamp u_tamper_stamp (
    .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_mon(now_mon), .now_year(now_year), .evt_low(evt_low),
    .evt_mid(evt_mid), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .flag_low(flag_low), .flag_mid(flag_mid), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); wr_en = 0; addr = a; #1 d = rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_now(input logic [47:0] t);
    {now_sec, now_min, now_hour, now_day, now_mon, now_year} = t;
  endtask

  task automatic fire(input int ch, input bit mid, input logic [47:0] t);
    @(negedge clk); set_now(t);
    if (mid) evt_mid[ch] = 1; else evt_low[ch] = 1;
    @(negedge clk); evt_low = '0; evt_mid = '0; set_now(48'h0);
  endtask

  task automatic chk_rec(input string tag, input int ch, input logic [47:0] exp);
    logic [7:0] d;
    for (int k = 0; k < 6; k++) begin
      rd(6'(ch * 8 + k + 1), d);
      chk(tag, d, exp[47 - 8*k -: 8]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(6'h20, d); chk("R1 status", d, 8'h00);
    rd(6'h22, d); chk("R1 mid", d, 8'h00);
    rd(6'h21, d); chk("R1 enable", d, 8'h00);
    rd(6'h00, d); chk("R1 ctrl0", d, 8'h40);
    rd(6'h19, d); chk("R1 ctrl3 rec byte", d, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_capture_low();
    logic [7:0] d;
    wr(6'h00, 8'h00);
    rd(6'h00, d); chk("R2 ctrl0 readback", d, 8'h00);
    fire(0, 0, 48'hD9_D9_E3_F1_F2_99);
    rd(6'h20, d); chk("R4 status after low", d, 8'h80);
    chk_rec("R2 R4 masked record", 0, 48'h59_59_23_31_12_99);
  endtask

  task automatic t_overwrite();
    fire(0, 0, 48'h07_15_08_02_03_24);
    chk_rec("R7 overwrite", 0, 48'h07_15_08_02_03_24);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    wr(6'h08, 8'h80);
    fire(1, 0, 48'h01_02_03_04_05_06);
    rd(6'h20, d); chk("R6 status ch1", d, 8'hC0);
    fire(1, 0, 48'h10_20_21_22_11_30);
    chk_rec("R6 held record", 1, 48'h01_02_03_04_05_06);
    wr(6'h20, 8'hBF);
    rd(6'h20, d); chk("R8 ch1 cleared", d, 8'h80);
    fire(1, 0, 48'h33_44_11_15_09_25);
    chk_rec("R6 after clear", 1, 48'h33_44_11_15_09_25);
  endtask

  task automatic t_off();
    logic [7:0] d;
    fire(2, 0, 48'h11_11_11_11_11_11);
    fire(2, 1, 48'h12_12_12_12_12_12);
    rd(6'h20, d); chk("R3 no low flag", d, 8'hC0);
    rd(6'h22, d); chk("R3 no mid flag", d, 8'h00);
    rd(6'h11, d); chk("R3 record untouched", d, 8'h00);
  endtask

  task automatic t_mid();
    logic [7:0] d;
    wr(6'h18, 8'h00);
    fire(3, 1, 48'h45_46_17_28_02_77);
    rd(6'h22, d); chk("R5 mid flag", d, 8'h10);
    rd(6'h20, d); chk("R5 low flags unchanged", d, 8'hC0);
    chk_rec("R5 record", 3, 48'h45_46_17_28_02_77);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(6'h20, 8'hFF);
    rd(6'h20, d); chk("R8 write ones no effect", d, 8'hC0);
    wr(6'h20, 8'h7F);
    rd(6'h20, d); chk("R8 clear ch0", d, 8'h40);
    @(negedge clk); addr = 6'h20; wdata = 8'h00; wr_en = 1; evt_low[0] = 1;
    @(negedge clk); wr_en = 0; evt_low = '0;
    rd(6'h20, d); chk("R8 event beats clear", d, 8'h80);
    wr(6'h20, 8'h00); wr(6'h22, 8'h00);
    rd(6'h20, d); chk("R8 all low clear", d, 8'h00);
    rd(6'h22, d); chk("R8 all mid clear", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(6'h21, 8'h20);
    fire(0, 0, 48'h01_01_01_01_01_01);
    #1 chk("R9 disabled source", {7'd0, irq_n}, 8'h01);
    wr(6'h21, 8'h80);
    #1 chk("R9 enabled source", {7'd0, irq_n}, 8'h00);
    wr(6'h20, 8'h00);
    #1 chk("R9 released", {7'd0, irq_n}, 8'h01);
    wr(6'h21, 8'h10);
    rd(6'h21, d); chk("R9 enable readback", d, 8'h10);
    fire(3, 1, 48'h02_02_02_02_02_02);
    #1 chk("R9 mid source", {7'd0, irq_n}, 8'h00);
    wr(6'h22, 8'h00);
    #1 chk("R9 mid released", {7'd0, irq_n}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_capture_low();
    t_overwrite();
    t_hold();
    t_off();
    t_mid();
    t_clear();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule